// File: doc/BRIEF.md
# Sector Erase Sequencer with Polled Status

This block runs sector and whole-array erase inside a parallel NOR flash and answers host reads while an erase is under way. A command decoder in front of it turns host writes into single-cycle strobes: queue a sector, erase everything, suspend and resume. An external mapper turns the write address into a sector number, so this block sees only sector indices. Queued sectors are kept in a bitmap. The first queued sector opens an acceptance window, during which more sectors may join the same operation. When the window closes, a busy period of fixed length follows. When the busy period ends, the block raises a one-cycle clear request for every queued sector, and the array logic fills those sectors with ones.

For every host read the block decides, one cycle later, whether the host sees a status byte or normal array data. The status byte uses four bits. Bit 7 is a completion flag. Bit 6 is a toggle that flips on each read while the erase runs. Bit 3 tells the window phase apart from the running phase. Bit 2 is a second toggle that keeps flipping on queued sectors while the erase is suspended. The window length and the erase duration are parameters counted in clock cycles.

Top module: `sectorEraseEngine`

## Requirements
- R1: After reset the block is idle: every read returns array data (`rdUseStatus`=0) and `eraseReq` is all zeros.
- R2: A sector strobe in idle queues that sector and opens the acceptance window. Status reads in the window have bit 7 = 0 and bit 3 = 0.
- R3: A sector strobe while the window is open (and not suspended) queues one more sector and restarts the window. The window closes `WINDOW_CYC` cycles after the last accepted strobe.
- R4: When the window closes, the busy phase lasts `ERASE_CYC` cycles, and status reads in it show bit 3 = 1 and bit 7 = 0. For a single sector strobe sampled at clock edge 0 with nothing after it, `eraseReq` equals the queued bitmap for exactly one cycle, following edge `WINDOW_CYC+ERASE_CYC`. The block is then idle and the queue is empty.
- R5: While the erase is active (window or busy, not suspended), every read returns status, whether or not its sector is queued. Bits 6 and 2 each invert between consecutive reads.
- R6: A suspend strobe during window or busy freezes the timers. Reads of queued sectors then return status with bit 7 = 1, bit 3 = 1, bit 6 unchanged between reads and bit 2 inverting. Reads of other sectors return array data.
- R7: A resume strobe while suspended restarts the erase in the busy phase. If the suspend came during the window, the busy phase starts with a full `ERASE_CYC` count from the resume edge. Reads after resume show bit 3 = 1 and bits 6 and 2 inverting again.
- R8: A chip-erase strobe in idle skips the window and enters the busy phase at once (bit 3 = 1). `eraseReq` becomes all ones `ERASE_CYC` cycles after the strobe edge.
- R9: The block ignores a sector strobe during the busy phase or suspend, a chip-erase strobe outside idle, a suspend strobe in idle, and a resume strobe when not suspended.
- R10: Bits 5, 4, 1 and 0 of every status byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addSector | input | 1 | Strobe: queue sector `cmdSector` for erase |
| chipErase | input | 1 | Strobe: erase the whole array |
| suspendReq | input | 1 | Strobe: suspend the running erase |
| resumeReq | input | 1 | Strobe: resume a suspended erase |
| cmdSector | input | SEC_W | Sector index that goes with `addSector` |
| rdStrobe | input | 1 | Host read request |
| rdSector | input | SEC_W | Sector index of the host read |
| rdValid | output | 1 | Read answer is valid (one cycle after `rdStrobe`) |
| rdUseStatus | output | 1 | 1: host gets `rdStatus`; 0: host gets array data |
| rdStatus | output | 8 | Status byte |
| eraseReq | output | NUM_SECTORS | One-cycle pulse: fill these sectors with ones |

## Verification
The bench sweeps a single-sector erase over every sector and counts the cycles to the clear pulse. A window timer that does not restart, or that is off by one, moves that count. A second sector that joins the erase late shows whether the window restarts. A design that did not restart it would issue the pulse too early, with the wrong bitmap. The suspend tests check three things: the toggles split correctly (bit 6 frozen, bit 2 still flipping), unqueued sectors fall back to data, and the busy timer stays frozen for a long stretch. A resume after a suspend in the window must skip the rest of the window and run exactly one full busy count. Strobes that arrive in the wrong phase must leave the final clear bitmap unchanged.

// File: rtl/eraseEnginePkg.sv
package eraseEnginePkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WINDOW = 2'd1,
    PH_BUSY   = 2'd2
  } phase_e;

  // strobes and phase flags from control to datapath
  typedef struct packed {
    logic addOne;     // queue the commanded sector
    logic addAll;     // queue every sector
    logic fire;       // busy count expired: clear queued sectors
    logic active;     // window or busy, not suspended
    logic inBusy;     // busy phase (suspended or not)
    logic suspended;  // erase held
  } engCtrl_t;

  localparam int BIT_POLL    = 7;
  localparam int BIT_TOGGLE  = 6;
  localparam int BIT_STARTED = 3;
  localparam int BIT_ALT     = 2;

endpackage

// File: rtl/eraseCtrl.sv
module eraseCtrl
  import eraseEnginePkg::*;
#(
  parameter int WINDOW_CYC = 6,
  parameter int ERASE_CYC  = 20
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     addSector,
  input  logic     chipErase,
  input  logic     suspendReq,
  input  logic     resumeReq,
  output engCtrl_t ctrl
);

  localparam int MAX_CYC = (WINDOW_CYC > ERASE_CYC) ? WINDOW_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WINDOW_CYC);
  localparam logic [CNT_W-1:0] ERS_LOAD = CNT_W'(ERASE_CYC);

  phase_e            phase;
  logic              susp;
  logic [CNT_W-1:0]  cnt;

  logic acceptChip, acceptAdd, acceptSusp, acceptRes, lastTick;

  always_comb begin
    acceptChip = chipErase && (phase == PH_IDLE);
    acceptAdd  = addSector && !acceptChip &&
                 ((phase == PH_IDLE) || ((phase == PH_WINDOW) && !susp));
    acceptSusp = suspendReq && (phase != PH_IDLE) && !susp;
    acceptRes  = resumeReq && susp;
    lastTick   = (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      susp  <= 1'b0;
      cnt   <= '0;
    end else if (acceptChip) begin
      phase <= PH_BUSY;
      cnt   <= ERS_LOAD;
    end else if (acceptAdd) begin
      phase <= PH_WINDOW;
      cnt   <= WIN_LOAD;
    end else if (acceptSusp) begin
      susp <= 1'b1;
    end else if (acceptRes) begin
      susp <= 1'b0;
      if (phase == PH_WINDOW) begin
        phase <= PH_BUSY;
        cnt   <= ERS_LOAD;
      end
    end else if (!susp && (phase != PH_IDLE)) begin
      if (lastTick) begin
        if (phase == PH_WINDOW) begin
          phase <= PH_BUSY;
          cnt   <= ERS_LOAD;
        end else begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctrl.addOne    = acceptAdd;
    ctrl.addAll    = acceptChip;
    ctrl.fire      = (phase == PH_BUSY) && !susp && lastTick && !acceptSusp;
    ctrl.active    = (phase != PH_IDLE) && !susp;
    ctrl.inBusy    = (phase == PH_BUSY);
    ctrl.suspended = susp;
  end

  // a held erase always belongs to a window or busy phase
  assert_susp_phase_R6: assert property (@(posedge clk) disable iff (!rstN)
    susp |-> (phase != PH_IDLE));

  // timer frozen while suspended
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    (susp && !resumeReq) |=> (cnt == $past(cnt)));

  // busy count steps down by one per cycle
  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_BUSY) && !susp && !suspendReq && (cnt > CNT_W'(1)))
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  // a chip erase never passes through the window
  assert_chip_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    acceptChip |=> (phase == PH_BUSY) && (cnt == ERS_LOAD));

endmodule

// File: rtl/sectorQueue.sv
module sectorQueue
  import eraseEnginePkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SEC_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  engCtrl_t               ctrl,
  input  logic [SEC_W-1:0]       cmdSector,
  output logic [NUM_SECTORS-1:0] queued,
  output logic [NUM_SECTORS-1:0] eraseReq
);

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_slot
    logic hit;
    assign hit = ctrl.addAll || (ctrl.addOne && (cmdSector == SEC_W'(g)));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        queued[g]   <= 1'b0;
        eraseReq[g] <= 1'b0;
      end else begin
        eraseReq[g] <= ctrl.fire && queued[g];
        if (ctrl.fire)
          queued[g] <= 1'b0;
        else if (hit)
          queued[g] <= 1'b1;
      end
    end
  end

  // queue empties on completion and the pulse carries the old queue
  assert_flush_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fire |=> (queued == '0) && (eraseReq == $past(queued)));

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|eraseReq) |=> (eraseReq == '0));

endmodule

// File: rtl/pollStatus.sv
module pollStatus
  import eraseEnginePkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SEC_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  engCtrl_t               ctrl,
  input  logic [NUM_SECTORS-1:0] queued,
  input  logic                   rdStrobe,
  input  logic [SEC_W-1:0]       rdSector,
  output logic                   rdValid,
  output logic                   rdUseStatus,
  output logic [7:0]             rdStatus
);

  logic togMain, togAlt;
  logic rdQueued, useStat, flipMain, flipAlt;
  logic [7:0] statWord;

  always_comb begin
    rdQueued = (int'(rdSector) < NUM_SECTORS) ? queued[rdSector] : 1'b0;
    useStat  = ctrl.active || (ctrl.suspended && rdQueued);
    flipMain = rdStrobe && ctrl.active;
    flipAlt  = rdStrobe && useStat;
    statWord = '0;
    if (useStat) begin
      statWord[BIT_POLL]    = ctrl.suspended;
      statWord[BIT_TOGGLE]  = togMain;
      statWord[BIT_STARTED] = ctrl.inBusy || ctrl.suspended;
      statWord[BIT_ALT]     = togAlt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      togMain     <= 1'b0;
      togAlt      <= 1'b0;
      rdValid     <= 1'b0;
      rdUseStatus <= 1'b0;
      rdStatus    <= '0;
    end else begin
      rdValid <= rdStrobe;
      if (flipMain) togMain <= !togMain;
      if (flipAlt)  togAlt  <= !togAlt;
      if (rdStrobe) begin
        rdUseStatus <= useStat;
        rdStatus    <= statWord;
      end
    end
  end

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdStatus[5:4] == 2'b00) && (rdStatus[1:0] == 2'b00));

  assert_active_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && ctrl.active) |=> rdUseStatus && !rdStatus[BIT_POLL]);

  assert_idle_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !ctrl.active && !ctrl.suspended) |=> !rdUseStatus);

endmodule

// File: rtl/sectorEraseEngine.sv
module sectorEraseEngine
  import eraseEnginePkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int WINDOW_CYC  = 6,
  parameter int ERASE_CYC   = 20,
  localparam int SEC_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   addSector,
  input  logic                   chipErase,
  input  logic                   suspendReq,
  input  logic                   resumeReq,
  input  logic [SEC_W-1:0]       cmdSector,
  input  logic                   rdStrobe,
  input  logic [SEC_W-1:0]       rdSector,
  output logic                   rdValid,
  output logic                   rdUseStatus,
  output logic [7:0]             rdStatus,
  output logic [NUM_SECTORS-1:0] eraseReq
);

  engCtrl_t               ctrl;
  logic [NUM_SECTORS-1:0] queued;

  eraseCtrl #(
    .WINDOW_CYC(WINDOW_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addSector (addSector),
    .chipErase (chipErase),
    .suspendReq(suspendReq),
    .resumeReq (resumeReq),
    .ctrl      (ctrl)
  );

  sectorQueue #(
    .NUM_SECTORS(NUM_SECTORS),
    .SEC_W      (SEC_W)
  ) i_queue (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cmdSector(cmdSector),
    .queued   (queued),
    .eraseReq (eraseReq)
  );

  pollStatus #(
    .NUM_SECTORS(NUM_SECTORS),
    .SEC_W      (SEC_W)
  ) i_status (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .queued     (queued),
    .rdStrobe   (rdStrobe),
    .rdSector   (rdSector),
    .rdValid    (rdValid),
    .rdUseStatus(rdUseStatus),
    .rdStatus   (rdStatus)
  );

  // the clear pulse only ever follows a busy cycle
  assert_fire_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|eraseReq) |-> $past(ctrl.inBusy));

endmodule

// File: tb/test_sectorEraseEngine.sv
module test_sectorEraseEngine;

  localparam int NS  = 8;
  localparam int WIN = 6;
  localparam int ERS = 20;
  localparam int SW  = $clog2(NS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addSector = 0, chipErase = 0, suspendReq = 0, resumeReq = 0;
  logic [SW-1:0] cmdSector = '0;
  logic rdStrobe = 0;
  logic [SW-1:0] rdSector = '0;
  logic rdValid, rdUseStatus;
  logic [7:0] rdStatus;
  logic [NS-1:0] eraseReq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sectorEraseEngine #(.NUM_SECTORS(NS), .WINDOW_CYC(WIN), .ERASE_CYC(ERS)) i_sectorEraseEngine (
    .clk(clk), .rstN(rstN), .addSector(addSector), .chipErase(chipErase),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .cmdSector(cmdSector),
    .rdStrobe(rdStrobe), .rdSector(rdSector), .rdValid(rdValid),
    .rdUseStatus(rdUseStatus), .rdStatus(rdStatus), .eraseReq(eraseReq)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 sector, 1 chip, 2 suspend, 3 resume
  task automatic pulse(input int kind, input int sec);
    @(negedge clk);
    cmdSector  = SW'(sec);
    addSector  = (kind == 0);
    chipErase  = (kind == 1);
    suspendReq = (kind == 2);
    resumeReq  = (kind == 3);
    @(negedge clk);
    addSector = 0; chipErase = 0; suspendReq = 0; resumeReq = 0;
  endtask

  task automatic rd(input int sec, output logic us, output logic [7:0] st);
    @(negedge clk);
    rdStrobe = 1; rdSector = SW'(sec);
    @(negedge clk);
    rdStrobe = 0;
    us = rdUseStatus;
    st = rdStatus;
  endtask

  task automatic waitDone(output int n, output logic [NS-1:0] m);
    n = 0; m = '0;
    while (n < 500) begin
      @(negedge clk);
      n++;
      if (|eraseReq) begin
        m = eraseReq;
        break;
      end
    end
  endtask

  task automatic idleCycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic us0, us1;
    logic [7:0] s0, s1;
    int n;
    logic [NS-1:0] m;

    idleCycles(3);
    rstN = 1;
    idleCycles(1);

    // R1 reset state
    checkEq("R1 eraseReq", int'(eraseReq), 0);
    rd(0, us0, s0);
    checkEq("R1 data", int'(us0), 0);

    // R4 sweep: every sector alone, exact completion timing
    for (int s = 0; s < NS; s++) begin
      pulse(0, s);
      waitDone(n, m);
      checkEq("R4 cycles", n, WIN + ERS);
      checkEq("R4 mask", int'(m), 1 << s);
      @(negedge clk);
      checkEq("R4 pulse end", int'(eraseReq), 0);
      rd(s, us0, s0);
      checkEq("R4 idle data", int'(us0), 0);
    end

    // R2 / R5 / R10 window and busy status
    pulse(0, 2);
    rd(2, us0, s0);
    rd(5, us1, s1);
    checkEq("R2 status", int'(us0), 1);
    checkEq("R2 dq3", int'(s0[3]), 0);
    checkEq("R2 dq7", int'(s0[7]), 0);
    checkEq("R5 unqueued status", int'(us1), 1);
    checkEq("R5 dq6 inv", int'(s1[6]), int'(!s0[6]));
    checkEq("R5 dq2 inv", int'(s1[2]), int'(!s0[2]));
    checkEq("R10 reserved", int'({s0[5:4], s0[1:0]}), 0);
    idleCycles(WIN + 2);
    rd(2, us0, s0);
    rd(2, us1, s1);
    checkEq("R4 dq3 busy", int'(s0[3]), 1);
    checkEq("R4 dq7 busy", int'(s0[7]), 0);
    checkEq("R5 busy dq6 inv", int'(s1[6]), int'(!s0[6]));
    checkEq("R10 reserved busy", int'({s1[5:4], s1[1:0]}), 0);
    waitDone(n, m);
    checkEq("R4 mask 2", int'(m), 1 << 2);

    // R3 window restart
    pulse(0, 1);
    idleCycles(WIN - 2);
    pulse(0, 4);
    waitDone(n, m);
    checkEq("R3 cycles", n, WIN + ERS);
    checkEq("R3 mask", int'(m), 8'h12);

    // R6 / R7 suspend in busy
    pulse(0, 3);
    idleCycles(WIN + 2);
    pulse(2, 0);
    rd(3, us0, s0);
    rd(3, us1, s1);
    checkEq("R6 queued status", int'(us0 & us1), 1);
    checkEq("R6 dq6 frozen", int'(s1[6]), int'(s0[6]));
    checkEq("R6 dq2 inv", int'(s1[2]), int'(!s0[2]));
    checkEq("R6 dq7", int'(s0[7]), 1);
    checkEq("R10 reserved susp", int'({s0[5:4], s0[1:0]}), 0);
    rd(6, us0, s0);
    checkEq("R6 unqueued data", int'(us0), 0);
    begin
      int seen = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (|eraseReq) seen++;
      end
      checkEq("R6 frozen", seen, 0);
    end
    pulse(3, 0);
    rd(6, us0, s0);
    rd(6, us1, s1);
    checkEq("R7 status", int'(us0 & us1), 1);
    checkEq("R7 dq3", int'(s0[3]), 1);
    checkEq("R7 dq6 inv", int'(s1[6]), int'(!s0[6]));
    checkEq("R7 dq2 inv", int'(s1[2]), int'(!s0[2]));
    waitDone(n, m);
    checkEq("R7 mask", int'(m), 1 << 3);

    // R7 suspend in window -> full busy after resume
    pulse(0, 0);
    pulse(2, 0);
    idleCycles(10);
    pulse(3, 0);
    waitDone(n, m);
    checkEq("R7 window resume cycles", n, ERS);
    checkEq("R7 window resume mask", int'(m), 1);

    // R8 chip erase
    pulse(1, 0);
    waitDone(n, m);
    checkEq("R8 cycles", n, ERS);
    checkEq("R8 mask", int'(m), (1 << NS) - 1);
    pulse(1, 0);
    rd(4, us0, s0);
    checkEq("R8 dq3", int'(s0[3]), 1);
    checkEq("R8 dq7", int'(s0[7]), 0);
    waitDone(n, m);
    checkEq("R8 mask 2", int'(m), (1 << NS) - 1);

    // R9 ignored strobes
    pulse(2, 0);
    pulse(3, 0);
    rd(2, us0, s0);
    checkEq("R9 idle suspend", int'(us0), 0);
    pulse(0, 5);
    waitDone(n, m);
    checkEq("R9 cycles", n, WIN + ERS);
    checkEq("R9 mask", int'(m), 1 << 5);
    pulse(0, 1);
    idleCycles(WIN + 2);
    pulse(0, 6);
    pulse(1, 0);
    pulse(3, 0);
    waitDone(n, m);
    checkEq("R9 busy ignores", int'(m), 1 << 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule